// File: doc/BRIEF.md
# Round-Parallel Lightweight Feistel Block Cipher Core

This core encrypts one block made of two W-bit words under a key made of four W-bit words. It completes one Feistel round in each clock cycle. The round uses a rotate-and-AND nonlinearity. The key schedule runs the same round function alongside the data path. In place of a round key, it feeds in a fixed constant word whose bit 0 is XORed with one bit from a small LFSR. The word width W can be 16, 24 or 32, which gives 32/64, 48/96 and 64/128-bit block/key sizes and 32, 36 or 44 rounds.

To use it, pulse `load_i` with `mode_i` high to capture a plaintext and a key. Then pulse `start_i`. When `done_o` is high, `ct_o` holds the ciphertext, and it stays stable until the next accepted load or start.

Top module: `lw_feistel_core`

## Requirements
- R1: After `rst_ni` is released, `done_o` is 0 and `ct_o` is all zeros.
- R2: When `load_i` and `mode_i` are both high on an idle clock edge, the core captures `pt_i` and `key_i` and clears `done_o`. From the next cycle `ct_o` equals `pt_i`, with the left word in the upper half and the right word in the lower half. Key word j is `key_i[W*j +: W]`, and word 0 is the first round key.
- R3: When `load_i` is high with `mode_i` low, nothing is loaded and `ct_o` keeps its value.
- R4: `start_i` is accepted on an idle edge when no load is accepted on the same edge. `done_o` then rises exactly ROUNDS clock edges later: 32 edges for W=16, 36 for W=24 and 44 for W=32.
- R5: Each round uses g(x) = (x AND rotl(x,5)) XOR rotl(x,1). The new left word is right XOR g(left) XOR the round key, and the old left word becomes the new right word. After the last round, `ct_o` holds the resulting {left, right}.
- R6: In each round the key words shift down by one place, so that word j takes the value of word j+1. Word 3 becomes word0 XOR g(word1) XOR K, where K has every bit set except bits 1 and 0, and bit 0 carries the LFSR output s[0]. The LFSR is loaded with all ones, and each round it steps to {s[0]^s[T], s[L-1:1]}. For W of 16 or 24, L=5 and T=2. For W=32, L=6 and T=1.
- R7: Once `done_o` is high, it stays high and `ct_o` stays stable until a load or start is accepted.
- R8: While rounds are running, `start_i` and `load_i` are ignored, and the result is not changed by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe |
| mode_i | input | 1 | Must be high for a load strobe to capture data |
| start_i | input | 1 | Begin the round sequence |
| pt_i | input | 2*WORD_W | Plaintext {left, right} |
| key_i | input | 4*WORD_W | Key, word 0 in the lowest bits |
| done_o | output | 1 | Ciphertext valid |
| ct_o | output | 2*WORD_W | Message state / ciphertext |

## Verification
The assertions assume that all inputs are known after reset. They also assume that `pt_i` holds its value over a capturing edge, since the load property compares `ct_o` against the sampled plaintext.

The stimulus drives every input at the falling clock edge and holds each strobe for exactly one cycle. It sends random keys and plaintexts from a fixed seed, along with directed all-zero, all-one and single-key-word cases. It also applies strobes deliberately during a run and with `mode_i` low, so that the ignore paths are exercised within those same assumptions.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  function automatic int unsigned rounds_for(int unsigned w);
    return (w == 16) ? 32 : (w == 24) ? 36 : 44;
  endfunction

  function automatic int unsigned lfsr_len(int unsigned w);
    return (w == 32) ? 6 : 5;
  endfunction

  function automatic int unsigned lfsr_tap(int unsigned w);
    return (w == 32) ? 1 : 2;
  endfunction
endpackage

// File: rtl/feistel_round.sv
module feistel_round #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic [W-1:0] rkey_i,
  output logic [W-1:0] left_o
);
  logic [W-1:0] rot5, rot1;
  assign rot5   = {left_i[W-6:0], left_i[W-1:W-5]};
  assign rot1   = {left_i[W-2:0], left_i[W-1]};
  assign left_o = right_i ^ ((left_i & rot5) ^ rot1) ^ rkey_i;
endmodule

// File: rtl/const_lfsr.sv
module const_lfsr #(
  parameter int unsigned LEN = 5,
  parameter int unsigned TAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic step_i,
  output logic bit_o
);
  logic [LEN-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '1;
    else if (seed_i) s_q <= '1;
    else if (step_i) s_q <= {s_q[0] ^ s_q[TAP], s_q[LEN-1:1]};
  end

  assign bit_o = s_q[0];
endmodule

// File: rtl/key_sched.sv
module key_sched #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [4*W-1:0] key_i,
  output logic [W-1:0] rkey_o
);
  import lwf_pkg::*;
  localparam int unsigned LEN = lfsr_len(W);
  localparam int unsigned TAP = lfsr_tap(W);

  logic [W-1:0] kq [4];
  logic [W-1:0] cword, k_new;
  logic         z;

  const_lfsr #(.LEN(LEN), .TAP(TAP)) i_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .seed_i(load_i),
    .step_i(step_i),
    .bit_o (z)
  );

  // constant: all ones except bits 1:0, LFSR bit in bit 0
  assign cword = {{(W-2){1'b1}}, 1'b0, z};

  feistel_round #(.W(W)) i_kround (
    .left_i (kq[1]),
    .right_i(kq[0]),
    .rkey_i (cword),
    .left_o (k_new)
  );

  for (genvar j = 0; j < 4; j++) begin : g_kw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      kq[j] <= '0;
      else if (load_i)  kq[j] <= key_i[W*j +: W];
      else if (step_i)  kq[j] <= (j == 3) ? k_new : kq[(j+1)%4];
    end
  end

  assign rkey_o = kq[0];
endmodule

// File: rtl/round_ctrl.sv
module round_ctrl #(
  parameter int unsigned ROUNDS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_req_i,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(ROUNDS + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic          start_acc;

  assign load_o    = load_req_i && !busy_q;
  assign start_acc = start_i && !busy_q && !load_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_o) begin
      done_q <= 1'b0;
    end else if (start_acc) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(ROUNDS - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/lw_feistel_core.sv
module lw_feistel_core #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  mode_i,
  input  logic                  start_i,
  input  logic [2*WORD_W-1:0]   pt_i,
  input  logic [4*WORD_W-1:0]   key_i,
  output logic                  done_o,
  output logic [2*WORD_W-1:0]   ct_o
);
  import lwf_pkg::*;
  localparam int unsigned ROUNDS = rounds_for(WORD_W);

  logic              load_en, busy;
  logic [WORD_W-1:0] l_q, r_q, l_new, rkey;

  round_ctrl #(.ROUNDS(ROUNDS)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_req_i(load_i && mode_i),
    .start_i   (start_i),
    .load_o    (load_en),
    .busy_o    (busy),
    .done_o    (done_o)
  );

  key_sched #(.W(WORD_W)) i_ks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_en),
    .step_i(busy),
    .key_i (key_i),
    .rkey_o(rkey)
  );

  feistel_round #(.W(WORD_W)) i_dround (
    .left_i (l_q),
    .right_i(r_q),
    .rkey_i (rkey),
    .left_o (l_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load_en) begin
      {l_q, r_q} <= pt_i;
    end else if (busy) begin
      l_q <= l_new;
      r_q <= l_q;
    end
  end

  assign ct_o = {l_q, r_q};
endmodule

// File: rtl/lwf_checks.sv
module lwf_checks #(
  parameter int unsigned WORD_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                load_i,
  input logic                mode_i,
  input logic                start_i,
  input logic [2*WORD_W-1:0] pt_i,
  input logic                done_o,
  input logic [2*WORD_W-1:0] ct_o,
  input logic                busy_q
);
  import lwf_pkg::*;
  localparam int unsigned ROUNDS = rounds_for(WORD_W);
  localparam int unsigned CW = $clog2(ROUNDS + 2);

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= '0;
    else if (start_i && !busy_q && !(load_i && mode_i)) run_cnt <= '0;
    else if (busy_q && run_cnt != '1) run_cnt <= run_cnt + 1'b1;
  end

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> run_cnt == CW'(ROUNDS));

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_q);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i && !busy_q) |=> (ct_o == $past(pt_i)) && !done_o);

  assert_mode_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !mode_i && !start_i && !busy_q) |=> $stable(ct_o));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !(load_i && mode_i)) |=> done_o && $stable(ct_o));

  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && run_cnt < CW'(ROUNDS - 1)) |=> busy_q);
endmodule

bind lw_feistel_core lwf_checks #(.WORD_W(WORD_W)) i_lwf_checks (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .mode_i (mode_i),
  .start_i(start_i),
  .pt_i   (pt_i),
  .done_o (done_o),
  .ct_o   (ct_o),
  .busy_q (busy)
);

// File: tb/test_lw_feistel_core.sv
`timescale 1ns/1ps
module test_lw_feistel_core;
  localparam int N  = 16;
  localparam int NR = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0, mode_i = 1'b0, start_i = 1'b0;
  logic [2*N-1:0] pt_i = '0;
  logic [4*N-1:0] key_i = '0;
  logic          done_o;
  logic [2*N-1:0] ct_o;

  int n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  lw_feistel_core #(.WORD_W(N)) i_lw_feistel_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .mode_i(mode_i),
    .start_i(start_i), .pt_i(pt_i), .key_i(key_i), .done_o(done_o), .ct_o(ct_o)
  );

  function automatic logic [N-1:0] g(input logic [N-1:0] x);
    logic [N-1:0] a, b;
    a = (x << 5) | (x >> (N-5));
    b = (x << 1) | (x >> (N-1));
    return (x & a) ^ b;
  endfunction

  function automatic logic [2*N-1:0] model(input logic [2*N-1:0] pt, input logic [4*N-1:0] key);
    logic [N-1:0] l, r, t, k0, k1, k2, k3, nk, c;
    logic [4:0]   s;
    {l, r} = pt;
    {k3, k2, k1, k0} = key;
    s = 5'h1f;
    for (int i = 0; i < NR; i++) begin
      c  = 16'hfffc | {15'd0, s[0]};
      t  = l;
      l  = r ^ g(l) ^ k0;
      r  = t;
      nk = k0 ^ g(k1) ^ c;
      k0 = k1; k1 = k2; k2 = k3; k3 = nk;
      s  = {s[0] ^ s[2], s[4:1]};
    end
    return {l, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full encryption; disturb=1 pulses strobes mid-run (R8)
  task automatic run_enc(input logic [2*N-1:0] pt, input logic [4*N-1:0] key, input string req, input bit disturb);
    logic [2*N-1:0] exp;
    exp = model(pt, key);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = 1'b1; pt_i = pt; key_i = key;
    @(negedge clk_i);
    load_i = 1'b0; mode_i = 1'b0;
    chk(ct_o == pt, "R2", 64'(ct_o), 64'(pt));
    chk(done_o == 1'b0, "R2", 64'(done_o), 64'd0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 1; i < NR; i++) begin
      if (disturb && i == 7) begin
        start_i = 1'b1; load_i = 1'b1; mode_i = 1'b1; pt_i = ~pt; key_i = ~key;
      end else begin
        start_i = 1'b0; load_i = 1'b0; mode_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0; load_i = 1'b0; mode_i = 1'b0;
    chk(done_o == 1'b0, "R4", 64'(done_o), 64'd0);
    @(negedge clk_i);
    chk(done_o == 1'b1, "R4", 64'(done_o), 64'd1);
    chk(ct_o == exp, req, 64'(ct_o), 64'(exp));
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b1 && ct_o == exp, "R7", 64'(ct_o), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "R1", 64'(done_o), 64'd0);
    chk(ct_o == '0, "R1", 64'(ct_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0 && ct_o == '0, "R1", 64'(ct_o), 64'd0);

    run_enc('0, '0, "R5", 1'b0);
    run_enc('1, '1, "R5", 1'b0);
    run_enc(32'h0000_0000, 64'h0001_0000_0000_0000, "R6", 1'b0);
    run_enc(32'h0000_0000, 64'h0000_0000_8000_0000, "R6", 1'b0);
    run_enc(32'h6565_6877, 64'h1918_1110_0908_0100, "R5", 1'b0);

    // R3: load strobe with mode low after a finished run
    @(negedge clk_i);
    begin
      logic [2*N-1:0] held;
      held = ct_o;
      load_i = 1'b1; mode_i = 1'b0; pt_i = ~held;
      @(negedge clk_i);
      load_i = 1'b0;
      chk(ct_o == held, "R3", 64'(ct_o), 64'(held));
      chk(done_o == 1'b1, "R3", 64'(done_o), 64'd1);
    end

    // R8: strobes mid-run
    run_enc(32'hdead_beef, 64'h0123_4567_89ab_cdef, "R8", 1'b1);

    for (int v = 0; v < 20; v++) begin
      run_enc($urandom(), {$urandom(), $urandom()}, "R5", 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule